// File: doc/BRIEF.md
# Bridge Fault Flag Monitor

This block watches the two full bridges of a bipolar motor driver and keeps one latched fault state per bridge. Open load (also a short to the supply or a shorted winding) is inferred when a direction reversal is not followed by inductive recirculation within a release window. A short to ground is latched as soon as it is sensed on an enabled bridge. After a further delay, that bridge is switched off. Each bridge has its own flags, so software can find a faulty winding by enabling the bridges one at a time.

Two shared active-low outputs report the combined state. A short to ground takes priority over open load. A thermal prealarm pulls both outputs low. The flags have no reset pin. They are cleared by control activity: a new direction reversal that shows recirculation, or driving both current-select bits of the bridge to zero. Leaving the all-off (inhibit) state with a direction input high flags open load until the first recirculation. Select and direction changes made too close together raise a spurious open-load flag. All sensing is modelled as digital inputs, and every delay is a parameter counted in clock cycles.

Top module: `bridge_fault_mon`

## Requirements
- R1: A direction edge on an enabled bridge (select not 00) starts a window of DIR_REL_DLY cycles. At the end of the window the bridge's open-load flag is set if recirc_i was not seen during the window, and cleared if it was. The flag keeps its old value until the window ends.
- R2: A direction edge taken while the bridge is in hold mode (select 01) sets open load at the end of the window, even when recirculation is seen.
- R3: A short to ground on an enabled bridge is latched. While it is latched, err1_no = 1 and err2_no = 0, whether or not open load is also flagged.
- R4: bridge_off_o of a shorted bridge rises SHORT_DLY cycles after its short flag is latched. It never rises without a latched short.
- R5: The outputs encode as {err1_no, err2_no}:
  - no fault gives 11;
  - open load only gives 01;
  - a short, alone or with open load, gives 10;
  - prealarm_i = 1 gives 00, overriding every fault.
- R6: The end of a direction window clears a latched short and its bridge_off_o. Open load is then cleared if recirculation was seen.
- R7: A select change to 00 clears all flags of that bridge SEL_REL_DLY cycles later, provided the select is still 00 at that point. The flags are unchanged in the cycle after the change.
- R8: When every select goes from 00 to non-zero (leaving inhibit), each enabled bridge whose direction input is high has open load set in the next cycle. The first recirc_i seen on that bridge while enabled clears it.
- R9: Open load is set spuriously in two cases:
  - a select change to non-zero comes fewer than DIR_SEL_WIN cycles after a direction edge of that bridge;
  - a direction edge comes fewer than SEL_DIR_WIN cycles after a select change of that bridge.
- R10: The flags of each bridge are set and cleared only by that bridge's own inputs.
- R11: After reset, err1_no = err2_no = 1 and bridge_off_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_i | input | N_BRIDGE | Direction input per bridge |
| sel_i | input | 2*N_BRIDGE | Current-select bits, two per bridge (bits 2b+1:2b); 00 off, 01 hold, 10 normal, 11 boost |
| recirc_i | input | N_BRIDGE | Recirculation observed on the bridge |
| gnd_short_i | input | N_BRIDGE | Short-to-ground comparator output |
| prealarm_i | input | 1 | Thermal prealarm |
| err1_no | output | 1 | Error output 1, active low |
| err2_no | output | 1 | Error output 2, active low |
| bridge_off_o | output | N_BRIDGE | Bridge disable request to the chopper sequencer |
| phase_chg_o | output | N_BRIDGE | One-cycle pulse after each direction edge |

## Verification
The assertions assume that inputs are synchronous to clk_i. They also assume that the short-to-ground input, once latched, is only cleared through a direction window or a select release. The assertion on the inhibit clear relies on a select of 00 being held for at least SEL_REL_DLY cycles before it is judged.

The stimulus changes inputs only on falling edges. Outside the R9 scenario, it leaves more than both guard windows between any select change and any direction edge, so that no spurious flag clouds the other checks.

// File: rtl/bfm_pkg.sv
package bfm_pkg;
  localparam logic [1:0] SEL_OFF  = 2'b00;
  localparam logic [1:0] SEL_HOLD = 2'b01;

  function automatic logic [1:0] encode_err(input logic pre, input logic any_ol, input logic any_sc);
    logic [1:0] e;
    if (pre)         e = 2'b00;
    else if (any_sc) e = 2'b10;
    else if (any_ol) e = 2'b01;
    else             e = 2'b11;
    return e;
  endfunction
endpackage

// File: rtl/bfm_win_cnt.sv
// Saturating cycles-since-event counter; busy_o while below LIMIT.
module bfm_win_cnt #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  output logic busy_o
);
  localparam int unsigned W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= LIM;
    else if (evt_i)      cnt_q <= '0;
    else if (cnt_q < LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign busy_o = cnt_q < LIM;
endmodule

// File: rtl/bfm_bridge_cell.sv
module bfm_bridge_cell
  import bfm_pkg::*;
#(
  parameter int unsigned SHORT_DLY   = 1500,
  parameter int unsigned DIR_REL_DLY = 150,
  parameter int unsigned SEL_REL_DLY = 50,
  parameter int unsigned SEL_DIR_WIN = 250,
  parameter int unsigned DIR_SEL_WIN = 600
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dir_i,
  input  logic [1:0] sel_i,
  input  logic       recirc_i,
  input  logic       short_i,
  input  logic       wake_i,
  output logic       ol_o,
  output logic       sc_o,
  output logic       off_o,
  output logic       phase_chg_o
);
  localparam int unsigned DW = $clog2(DIR_REL_DLY + 1);
  localparam int unsigned RW = $clog2(SEL_REL_DLY + 1);
  localparam int unsigned SW = $clog2(SHORT_DLY + 1);

  logic          dir_q, chg_q, ol_q, sc_q, off_q, wake_q, seen_q, forced_q;
  logic [1:0]    sel_q;
  logic [DW-1:0] watch_q;
  logic [RW-1:0] rel_q;
  logic [SW-1:0] sc_cnt_q;
  logic          active, dir_edge, sel_edge, dir_recent, sel_recent;

  assign active   = sel_i != SEL_OFF;
  assign dir_edge = dir_i ^ dir_q;
  assign sel_edge = sel_i != sel_q;

  bfm_win_cnt #(.LIMIT(DIR_SEL_WIN)) i_dir_win (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(dir_edge), .busy_o(dir_recent));
  bfm_win_cnt #(.LIMIT(SEL_DIR_WIN)) i_sel_win (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(sel_edge), .busy_o(sel_recent));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q    <= 1'b0;
      sel_q    <= SEL_OFF;
      chg_q    <= 1'b0;
      ol_q     <= 1'b0;
      sc_q     <= 1'b0;
      off_q    <= 1'b0;
      wake_q   <= 1'b0;
      seen_q   <= 1'b0;
      forced_q <= 1'b0;
      watch_q  <= '0;
      rel_q    <= '0;
      sc_cnt_q <= '0;
    end else begin
      dir_q <= dir_i;
      sel_q <= sel_i;
      chg_q <= dir_edge;

      // leaving inhibit with direction high
      if (wake_i && dir_i && active) begin
        ol_q   <= 1'b1;
        wake_q <= 1'b1;
      end else if (wake_q && active && recirc_i) begin
        ol_q   <= 1'b0;
        wake_q <= 1'b0;
      end

      // spurious flag: select change too soon after direction edge
      if (sel_edge && active && dir_recent) ol_q <= 1'b1;

      // direction window
      if (dir_edge && active) begin
        watch_q  <= DW'(DIR_REL_DLY);
        seen_q   <= 1'b0;
        forced_q <= (sel_i == SEL_HOLD) || sel_recent;
      end else if (watch_q != '0) begin
        if (!active) begin
          watch_q <= '0;
        end else begin
          watch_q <= watch_q - 1'b1;
          seen_q  <= seen_q | recirc_i;
          if (watch_q == DW'(1)) begin
            ol_q     <= forced_q | ~(seen_q | recirc_i);
            wake_q   <= 1'b0;
            sc_q     <= 1'b0;
            off_q    <= 1'b0;
            sc_cnt_q <= '0;
          end
        end
      end

      // select release to off
      if (sel_edge && !active) begin
        rel_q <= RW'(SEL_REL_DLY);
      end else if (rel_q != '0) begin
        rel_q <= rel_q - 1'b1;
        if (rel_q == RW'(1) && !active) begin
          ol_q     <= 1'b0;
          wake_q   <= 1'b0;
          sc_q     <= 1'b0;
          off_q    <= 1'b0;
          sc_cnt_q <= '0;
        end
      end

      // short to ground and delayed shutdown
      if (!sc_q) begin
        if (short_i && active && !(watch_q == DW'(1))) begin
          sc_q     <= 1'b1;
          sc_cnt_q <= '0;
        end
      end else if (!off_q && !(watch_q == DW'(1)) && !(rel_q == RW'(1) && !active)) begin
        sc_cnt_q <= sc_cnt_q + 1'b1;
        if (sc_cnt_q == SW'(SHORT_DLY - 1)) off_q <= 1'b1;
      end
    end
  end

  assign ol_o        = ol_q;
  assign sc_o        = sc_q;
  assign off_o       = off_q;
  assign phase_chg_o = chg_q;

  // R4
  off_needs_short_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_q |-> sc_q);
  // R4
  off_not_early_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sc_q) |=> !off_q);
  // R7
  inhibit_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active && $past(!active) && rel_q == '0 && $past(rel_q) == '0) |-> (!ol_q && !sc_q));
endmodule

// File: rtl/bridge_fault_mon.sv
module bridge_fault_mon
  import bfm_pkg::*;
#(
  parameter int unsigned N_BRIDGE    = 2,
  parameter int unsigned SHORT_DLY   = 1500,
  parameter int unsigned DIR_REL_DLY = 150,
  parameter int unsigned SEL_REL_DLY = 50,
  parameter int unsigned SEL_DIR_WIN = 250,
  parameter int unsigned DIR_SEL_WIN = 600
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_BRIDGE-1:0]   dir_i,
  input  logic [2*N_BRIDGE-1:0] sel_i,
  input  logic [N_BRIDGE-1:0]   recirc_i,
  input  logic [N_BRIDGE-1:0]   gnd_short_i,
  input  logic                  prealarm_i,
  output logic                  err1_no,
  output logic                  err2_no,
  output logic [N_BRIDGE-1:0]   bridge_off_o,
  output logic [N_BRIDGE-1:0]   phase_chg_o
);
  logic                inh_q, wake;
  logic [N_BRIDGE-1:0] ol, sc;
  logic [1:0]          err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inh_q <= 1'b1;
    else         inh_q <= ~(|sel_i);
  end

  assign wake = inh_q && (|sel_i);

  for (genvar b = 0; b < N_BRIDGE; b++) begin : g_br
    bfm_bridge_cell #(
      .SHORT_DLY  (SHORT_DLY),
      .DIR_REL_DLY(DIR_REL_DLY),
      .SEL_REL_DLY(SEL_REL_DLY),
      .SEL_DIR_WIN(SEL_DIR_WIN),
      .DIR_SEL_WIN(DIR_SEL_WIN)
    ) i_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .dir_i      (dir_i[b]),
      .sel_i      (sel_i[2*b+1 -: 2]),
      .recirc_i   (recirc_i[b]),
      .short_i    (gnd_short_i[b]),
      .wake_i     (wake),
      .ol_o       (ol[b]),
      .sc_o       (sc[b]),
      .off_o      (bridge_off_o[b]),
      .phase_chg_o(phase_chg_o[b])
    );
  end

  assign err     = encode_err(prealarm_i, |ol, |sc);
  assign err1_no = err[1];
  assign err2_no = err[0];

  // R5
  prealarm_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prealarm_i |-> (!err1_no && !err2_no));
  // R3
  short_dominant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|bridge_off_o) && !prealarm_i) |-> (err1_no && !err2_no));
endmodule

// File: tb/test_bridge_fault_mon.sv
module test_bridge_fault_mon;
  localparam int NB   = 2;
  localparam int SHD  = 40;
  localparam int DREL = 12;
  localparam int SREL = 5;
  localparam int SDW  = 20;
  localparam int DSW  = 30;
  localparam int GAP  = 40;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NB-1:0]   dir = '0, rec = '0, sht = '0;
  logic [2*NB-1:0] sel = '0;
  logic            pre = 1'b0;
  logic            err1_n, err2_n;
  logic [NB-1:0]   off, chg;
  int              total = 0, bad = 0;

  always #10 clk = ~clk;

  bridge_fault_mon #(
    .N_BRIDGE(NB), .SHORT_DLY(SHD), .DIR_REL_DLY(DREL), .SEL_REL_DLY(SREL),
    .SEL_DIR_WIN(SDW), .DIR_SEL_WIN(DSW)
  ) i_bridge_fault_mon (
    .clk_i(clk), .rst_ni(rst_n), .dir_i(dir), .sel_i(sel), .recirc_i(rec),
    .gnd_short_i(sht), .prealarm_i(pre), .err1_no(err1_n), .err2_no(err2_n),
    .bridge_off_o(off), .phase_chg_o(chg)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_err(input string tag, input logic [1:0] exp);
    chk(tag, {30'd0, err1_n, err2_n}, {30'd0, exp});
  endtask

  task automatic set_sel(input int b, input logic [1:0] v);
    sel[2*b +: 2] = v;
  endtask

  task automatic flip(input int b, input logic with_rec);
    dir[b] = ~dir[b];
    if (with_rec) begin
      tick(3); rec[b] = 1'b1; tick(1); rec[b] = 1'b0;
      tick(DREL);
    end else begin
      tick(DREL + 3);
    end
  endtask

  task automatic t_reset;
    tick(3);
    chk_err("R11 reset err", 2'b11);
    chk("R11 reset off", {30'd0, off}, 32'd0);
    rst_n = 1'b1;
    tick(2);
    chk_err("R11 after release", 2'b11);
  endtask

  task automatic t_open_load;
    set_sel(0, 2'b10);
    tick(GAP);
    chk_err("R1 enabled no fault", 2'b11);
    dir[0] = 1'b1;
    tick(2);
    chk_err("R1 flag held in window", 2'b11);
    chk("R1 phase change pulse", {31'd0, chg[0]}, 32'd0);
    tick(DREL + 1);
    chk_err("R1 no recirculation", 2'b01);
    dir[0] = 1'b0;
    tick(1);
    chk_err("R6 flag kept until window end", 2'b01);
    tick(2); rec[0] = 1'b1; tick(1); rec[0] = 1'b0;
    tick(DREL);
    chk_err("R6 cleared by recirculating reversal", 2'b11);
    tick(GAP);
  endtask

  task automatic t_hold;
    set_sel(0, 2'b01);
    tick(GAP);
    flip(0, 1'b1);
    chk_err("R2 hold reversal", 2'b01);
    tick(GAP);
    set_sel(0, 2'b00);
    tick(1);
    chk_err("R7 held right after select off", 2'b01);
    tick(SREL + 2);
    chk_err("R7 cleared by select off", 2'b11);
  endtask

  task automatic t_wake;
    // dir[0] is high here
    set_sel(0, 2'b10);
    tick(2);
    chk_err("R8 wake with dir high", 2'b01);
    tick(4);
    rec[0] = 1'b1; tick(1); rec[0] = 1'b0;
    tick(2);
    chk_err("R8 first recirculation clears", 2'b11);
    tick(GAP);
  endtask

  task automatic t_short;
    flip(0, 1'b0);
    chk_err("R1 open load before short", 2'b01);
    sht[0] = 1'b1;
    tick(2);
    chk_err("R3 short dominant over open load", 2'b10);
    tick(SHD - 4);
    chk("R4 off not yet", {31'd0, off[0]}, 32'd0);
    tick(6);
    chk("R4 off after delay", {31'd0, off[0]}, 32'd1);
    chk("R10 other bridge on", {31'd0, off[1]}, 32'd0);
    sht[0] = 1'b0;
    tick(2);
    chk_err("R3 latched after input drops", 2'b10);
    flip(0, 1'b1);
    chk_err("R6 reversal clears short", 2'b11);
    chk("R6 off released", {31'd0, off[0]}, 32'd0);
    tick(GAP);
  endtask

  task automatic t_prealarm;
    pre = 1'b1;
    tick(1);
    chk_err("R5 prealarm only", 2'b00);
    flip(0, 1'b0);
    chk_err("R5 prealarm over open load", 2'b00);
    pre = 1'b0;
    tick(1);
    chk_err("R5 open load after prealarm", 2'b01);
    flip(0, 1'b1);
    chk_err("R5 no fault", 2'b11);
    tick(GAP);
  endtask

  task automatic t_indep;
    set_sel(1, 2'b10);
    tick(GAP);
    flip(1, 1'b0);
    chk_err("R10 bridge1 open load", 2'b01);
    set_sel(0, 2'b00);
    tick(SREL + 3);
    chk_err("R10 bridge0 release keeps bridge1 flag", 2'b01);
    flip(1, 1'b1);
    chk_err("R10 bridge1 cleared", 2'b11);
    tick(GAP);
  endtask

  task automatic t_spurious;
    flip(1, 1'b1);
    chk_err("R9 clean reversal", 2'b11);
    dir[1] = ~dir[1];
    tick(5);
    set_sel(1, 2'b11);
    tick(2);
    chk_err("R9 select soon after reversal", 2'b01);
    tick(DREL + GAP);
    flip(1, 1'b1);
    chk_err("R9 cleared", 2'b11);
    tick(GAP);
    set_sel(1, 2'b10);
    tick(5);
    flip(1, 1'b1);
    chk_err("R9 reversal soon after select", 2'b01);
    tick(GAP);
    set_sel(1, 2'b00);
    tick(SREL + 3);
    chk_err("R7 cleared via select off", 2'b11);
  endtask

  initial begin
    t_reset();
    t_open_load();
    t_hold();
    t_wake();
    t_short();
    t_prealarm();
    t_indep();
    t_spurious();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(100000);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule